// File: doc/BRIEF.md
# Button Scroll Auto-Repeat Generator

This block turns four scroll buttons into a stream of scroll steps. The buttons are active low and idle high through pull-ups. There is one button each for up, down, left and right. Each input is filtered by a debouncer. After that, one button becomes the owner of the scroll channel. The block issues one step when the owner is pressed and keeps repeating steps while the owner is held.

The repeat runs at two speeds. The first few repeats are spaced by a long interval. Every later repeat is spaced by a short interval. Releasing the owner stops the stream at once, and the next press starts again at the slow rate. Each step is a single-cycle pulse. It comes with an axis bit and a direction bit that a downstream packet builder can use.

All timings are cycle-count parameters. The defaults assume a 6 MHz clock: 10 ms debounce, 320 ms slow interval and 40 ms fast interval. A simulation can use much shorter counts.

Top module: `scroll_repeat`

## Requirements
- R1: Button inputs are active low. Index 0 is up, 1 is down, 2 is left and 3 is right. With each step, `axis_o` is 0 for up/down and 1 for left/right, and `dir_o` is 0 for up/left and 1 for down/right.
- R2: A low pulse shorter than `DEBOUNCE_CYC` cycles on a button produces no step.
- R3: The first step of a press comes no earlier than `DEBOUNCE_CYC` and no later than `DEBOUNCE_CYC`+5 cycles after the input goes low.
- R4: While the owner is held, the first `SLOW_REPEATS` repeats each follow the previous step by exactly `SLOW_CYC` cycles.
- R5: Every later repeat follows the previous step by exactly `FAST_CYC` cycles.
- R6: Releasing the owner stops further steps. A new press starts again with the slow interval.
- R7: While the owner is held, pressing other buttons has no effect on the steps or their axis and direction.
- R8: When several buttons become pressed in the same cycle, the lowest index wins.
- R9: When the owner is released while another button is still held, that button takes over. Its first step comes within `DEBOUNCE_CYC`+6 cycles of the release.
- R10: `step_o` is never high in two consecutive cycles.
- R11: `step_o` is low during reset and stays low while no button is pressed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_ni | input | 4 | Scroll buttons, active low: up, down, left, right at bits 0..3 |
| step_o | output | 1 | One-cycle scroll step pulse |
| axis_o | output | 1 | 0 vertical, 1 horizontal (valid with step_o) |
| dir_o | output | 1 | 0 up/left, 1 down/right (valid with step_o) |

## Verification
The hardest case to reach is the hand-over of ownership while the stream is already in its fast phase. A second button must already be held and debounced when the owner is released, so that its take-over step can be told apart from the owner's repeats. The stimulus presses the loser after the owner's first step, waits out several repeats, and then releases only the owner. It then measures both the code change and the latency. A sweep over all four buttons checks the exact spacing of every slow and fast interval. It also releases each button just after a fast step, to show that no step slips out during the release debounce.

// File: rtl/scroll_repeat_pkg.sv
package scroll_repeat_pkg;
  localparam int unsigned NUM_BTN   = 4;
  localparam int unsigned BTN_IDX_W = $clog2(NUM_BTN);
  typedef logic [BTN_IDX_W-1:0] btn_idx_t;
endpackage

// File: rtl/sr_debounce.sv
module sr_debounce #(
  parameter int unsigned DEB_CYC = 60000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_ni,
  output logic pressed_o
);
  localparam int unsigned CNT_W = (DEB_CYC > 1) ? $clog2(DEB_CYC) : 1;

  logic             sync1_q, sync2_q, level_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= raw_ni;
      sync2_q <= sync1_q;
    end
  end

  // level flips only after DEB_CYC consecutive mismatching samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b1;
      cnt_q   <= '0;
    end else if (sync2_q != level_q) begin
      if (cnt_q == CNT_W'(DEB_CYC - 1)) begin
        level_q <= sync2_q;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign pressed_o = ~level_q;
endmodule

// File: rtl/sr_owner_arb.sv
module sr_owner_arb
  import scroll_repeat_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_BTN-1:0] pressed_i,
  output logic               own_vld_o,
  output btn_idx_t           own_idx_o,
  output logic               take_o
);
  btn_idx_t pick;
  logic     any;

  // lowest index wins among simultaneous candidates
  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int i = NUM_BTN - 1; i >= 0; i--) begin
      if (pressed_i[i]) begin
        pick = btn_idx_t'(i);
        any  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_vld_o <= 1'b0;
      own_idx_o <= '0;
      take_o    <= 1'b0;
    end else begin
      take_o <= 1'b0;
      if (own_vld_o) begin
        if (!pressed_i[own_idx_o]) own_vld_o <= 1'b0;
      end else if (any) begin
        own_vld_o <= 1'b1;
        own_idx_o <= pick;
        take_o    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sr_rep_timer.sv
module sr_rep_timer
  import scroll_repeat_pkg::*;
#(
  parameter int unsigned SLOW_CYC     = 1920000,
  parameter int unsigned FAST_CYC     = 240000,
  parameter int unsigned SLOW_REPEATS = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     own_vld_i,
  input  btn_idx_t own_idx_i,
  input  logic     take_i,
  output logic     step_o,
  output btn_idx_t code_o
);
  localparam int unsigned MAX_CYC = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
  localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam int unsigned REP_W   = $clog2(SLOW_REPEATS + 1);

  logic [CNT_W-1:0] cnt_q, ival_m1;
  logic [REP_W-1:0] rep_q;
  logic             due;

  assign ival_m1 = (rep_q < REP_W'(SLOW_REPEATS)) ? CNT_W'(SLOW_CYC - 1)
                                                  : CNT_W'(FAST_CYC - 1);
  assign due = own_vld_i && !take_i && (cnt_q == ival_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rep_q  <= '0;
      step_o <= 1'b0;
      code_o <= '0;
    end else begin
      step_o <= take_i | due;
      if (take_i || due) code_o <= own_idx_i;
      if (!own_vld_i || take_i) begin
        cnt_q <= '0;
        rep_q <= '0;
      end else if (due) begin
        cnt_q <= '0;
        if (rep_q < REP_W'(SLOW_REPEATS)) rep_q <= rep_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scroll_repeat.sv
module scroll_repeat
  import scroll_repeat_pkg::*;
#(
  parameter int unsigned DEBOUNCE_CYC = 60000,
  parameter int unsigned SLOW_CYC     = 1920000,
  parameter int unsigned FAST_CYC     = 240000,
  parameter int unsigned SLOW_REPEATS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_BTN-1:0] btn_ni,
  output logic               step_o,
  output logic               axis_o,
  output logic               dir_o
);
  logic [NUM_BTN-1:0] pressed_w;
  logic               own_vld_w, take_w;
  btn_idx_t           own_idx_w, code_w;

  for (genvar g = 0; g < NUM_BTN; g++) begin : g_deb
    sr_debounce #(.DEB_CYC(DEBOUNCE_CYC)) u_deb (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .raw_ni   (btn_ni[g]),
      .pressed_o(pressed_w[g])
    );
  end

  sr_owner_arb u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pressed_i(pressed_w),
    .own_vld_o(own_vld_w),
    .own_idx_o(own_idx_w),
    .take_o   (take_w)
  );

  sr_rep_timer #(
    .SLOW_CYC    (SLOW_CYC),
    .FAST_CYC    (FAST_CYC),
    .SLOW_REPEATS(SLOW_REPEATS)
  ) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .own_vld_i(own_vld_w),
    .own_idx_i(own_idx_w),
    .take_i   (take_w),
    .step_o   (step_o),
    .code_o   (code_w)
  );

  assign axis_o = code_w[1];
  assign dir_o  = code_w[0];
endmodule

// File: rtl/scroll_repeat_chk.sv
module scroll_repeat_chk
  import scroll_repeat_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               step_o,
  input logic               axis_o,
  input logic               dir_o,
  input logic [NUM_BTN-1:0] pressed_i,
  input logic               own_vld_i,
  input btn_idx_t           own_idx_i
);
  p_single_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o);

  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !own_vld_i |=> !step_o);

  p_owner_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_vld_i && pressed_i[own_idx_i]) |=> (own_vld_i && $stable(own_idx_i)));

  p_release_drops_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_vld_i && !pressed_i[own_idx_i]) |=> !own_vld_i);

  p_code_matches_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> ({axis_o, dir_o} == $past(own_idx_i)));
endmodule

bind scroll_repeat scroll_repeat_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .step_o   (step_o),
  .axis_o   (axis_o),
  .dir_o    (dir_o),
  .pressed_i(pressed_w),
  .own_vld_i(own_vld_w),
  .own_idx_i(own_idx_w)
);

// File: tb/scroll_repeat_tb.sv
module scroll_repeat_tb;
  localparam int DEB  = 8;
  localparam int SLOW = 48;
  localparam int FAST = 16;
  localparam int REPS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] btn_n = 4'hF;
  logic       step, axis, dir;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int n_st  = 0;
  int dbl   = 0;
  int st_cyc [64];
  int st_code[64];
  logic prev_step = 1'b0;

  always #2 clk = ~clk;

  scroll_repeat #(
    .DEBOUNCE_CYC(DEB), .SLOW_CYC(SLOW), .FAST_CYC(FAST), .SLOW_REPEATS(REPS)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .btn_ni(btn_n),
    .step_o(step), .axis_o(axis), .dir_o(dir)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (step) begin
        if (n_st < 64) begin
          st_cyc[n_st]  = cyc;
          st_code[n_st] = {30'd0, axis, dir};
        end
        n_st = n_st + 1;
      end
      if (prev_step && step) dbl = dbl + 1;
      prev_step = step;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_steps(input int n, input int lim);
    int k = 0;
    while (n_st < n && k < lim) begin
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    chk(step == 1'b0, "R11 step in reset", int'(step), 0);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    chk(n_st == 0, "R11 idle steps", n_st, 0);

    // R1 R3 R4 R5 R6: sweep all buttons, each press restarts slow
    for (int b = 0; b < 4; b++) begin
      n_st = 0;
      @(negedge clk);
      t0 = cyc;
      btn_n[b] = 1'b0;
      wait_steps(REPS + 4, 2000);
      btn_n = 4'hF;
      repeat (DEB + 30) @(negedge clk);
      chk(n_st == REPS + 4, "R6 steps stop on release", n_st, REPS + 4);
      chk(st_cyc[0] - t0 >= DEB && st_cyc[0] - t0 <= DEB + 5,
          "R3 first step latency", st_cyc[0] - t0, DEB + 4);
      for (int i = 1; i <= REPS + 3; i++) begin
        if (i <= REPS)
          chk(st_cyc[i] - st_cyc[i-1] == SLOW, "R4 slow interval",
              st_cyc[i] - st_cyc[i-1], SLOW);
        else
          chk(st_cyc[i] - st_cyc[i-1] == FAST, "R5 fast interval",
              st_cyc[i] - st_cyc[i-1], FAST);
      end
      for (int i = 0; i < REPS + 4; i++)
        chk(st_code[i] == b, "R1 axis/dir code", st_code[i], b);
    end

    // R2: short glitches on every button
    n_st = 0;
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      btn_n[b] = 1'b0;
      repeat (DEB - 2) @(negedge clk);
      btn_n[b] = 1'b1;
      repeat (10) @(negedge clk);
    end
    repeat (DEB + 20) @(negedge clk);
    chk(n_st == 0, "R2 glitch ignored", n_st, 0);

    // R7 R9: right owns, up pressed later, then right released
    n_st = 0;
    @(negedge clk);
    btn_n[3] = 1'b0;
    wait_steps(1, 200);
    btn_n[0] = 1'b0;
    wait_steps(REPS + 3, 2000);
    for (int i = 0; i < REPS + 3; i++)
      chk(st_code[i] == 3, "R7 owner keeps channel", st_code[i], 3);
    btn_n[3] = 1'b1;
    t0 = cyc;
    n_st = 0;
    wait_steps(1, 200);
    chk(n_st == 1 && st_code[0] == 0, "R9 takeover code", st_code[0], 0);
    chk(st_cyc[0] - t0 >= DEB && st_cyc[0] - t0 <= DEB + 6,
        "R9 takeover latency", st_cyc[0] - t0, DEB + 5);
    btn_n = 4'hF;
    repeat (DEB + 30) @(negedge clk);

    // R8: simultaneous presses
    n_st = 0;
    @(negedge clk);
    btn_n = 4'b1001;
    wait_steps(1, 200);
    chk(st_code[0] == 1, "R8 down beats left", st_code[0], 1);
    btn_n = 4'hF;
    repeat (DEB + 30) @(negedge clk);
    n_st = 0;
    @(negedge clk);
    btn_n = 4'h0;
    wait_steps(1, 200);
    chk(st_code[0] == 0, "R8 up beats all", st_code[0], 0);
    btn_n = 4'hF;
    repeat (DEB + 30) @(negedge clk);

    chk(dbl == 0, "R10 single-cycle pulse", dbl, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule